// File: doc/BRIEF.md
# Address Translation Window Table

A programmable set of address translation windows for a bus bridge. Each window holds an enable bit, a type code, a base address, a limit and a target address. Software programs them through a small register port that carries a write strobe, a window number and a field selector. Each incoming request address is compared with every enabled memory-type window. On a hit the address is moved onto the window's target, and the index of the winning window is reported. On a miss the address goes through unchanged with the hit flag low.

Windows are built from whole chunks of a minimum region size that is fixed at build time. The low bits of the limit register always read as ones, and the low bits of base and target always read as zeros. The limit register covers only the lower half of the address. A window therefore shares every address bit above that half with its base, and it cannot cross that boundary. Either the inbound or the outbound table of a bridge is one instance of this block, each instance with its own window count.

Top module: `xlat_window_table`

## Requirements
- R1: After reset every window is disabled and its control field reads zero. A lookup before any programming misses.
- R2: Field select codes are 0 control, 1 base low word, 2 base high word, 3 limit, 4 target low word, 5 target high word. A read returns the stored value of the addressed field. Codes 6 and 7 read zero, and a write to them changes no field.
- R3: The limit bits below the minimum region size are hardwired to ones, and writes to them are dropped. The region sizes 4096, 8192, 16384, 32768 and 65536 give the masks 0xFFF, 0x1FFF, 0x3FFF, 0x7FFF and 0xFFFF. Any other size gives 0xFFFF.
- R4: A window hits when it is enabled, has type 0 (memory), its upper address word equals the request's upper word, and its base low word <= request low word <= its limit.
- R5: On a hit the response address is target + (request - base).
- R6: On a miss the response address equals the request address, the hit flag is 0 and the index is 0.
- R7: When several windows hit, the lowest index wins.
- R8: The response valid, address, hit flag and index appear one cycle after the request, all together. With no request, the response valid is low.
- R9: A register write affects lookups presented in the next cycle or later. A lookup in the same cycle as the write uses the old contents.
- R10: The base and target bits below the minimum region size read as zero, whatever value was written.
- R11: In the control field, bit 0 is the enable and bits 5:1 are the type. An enabled window with a non-zero type never hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_idx_i | input | IDX_W | Window number for read and write |
| reg_sel_i | input | 3 | Field select |
| reg_wdata_i | input | REG_W | Write data |
| reg_rdata_o | output | REG_W | Read data for the addressed field (combinational) |
| req_valid_i | input | 1 | Lookup request valid |
| req_addr_i | input | ADDR_W | Request address |
| rsp_valid_o | output | 1 | Response valid |
| rsp_addr_o | output | ADDR_W | Translated or passed-through address |
| rsp_hit_o | output | 1 | A window matched |
| rsp_idx_o | output | IDX_W | Index of the winning window |

## Verification
The main instance is built with four windows, 64-bit addresses, 32-bit registers and an 8192-byte minimum region. The mask is then 0x1FFF, not the fallback value, so any mix-up between mask widths shows up in the limit readback and at the window edges. Two of its windows overlap, which exercises the priority rule. A second instance with two windows and a region size of 5000 checks the fallback mask through a limit read.

// File: rtl/xwt_pkg.sv
package xwt_pkg;

  localparam int TYPE_W = 5;
  localparam logic [TYPE_W-1:0] TYPE_MEM = '0;

  typedef enum logic [2:0] {
    FLD_CTRL    = 3'd0,
    FLD_BASE_LO = 3'd1,
    FLD_BASE_HI = 3'd2,
    FLD_LIMIT   = 3'd3,
    FLD_TGT_LO  = 3'd4,
    FLD_TGT_HI  = 3'd5
  } fld_e;

  // number of hardwired low bits for a minimum region size
  function automatic int chunk_bits(input int unsigned bytes);
    case (bytes)
      4096:    return 12;
      8192:    return 13;
      16384:   return 14;
      32768:   return 15;
      65536:   return 16;
      default: return 16;
    endcase
  endfunction

endpackage

// File: rtl/xwt_regfile.sv
module xwt_regfile
  import xwt_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int ADDR_W  = 64,
  parameter int REG_W   = 32,
  parameter int LOW_W   = 12,
  parameter int IDX_W   = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [2:0]             sel_i,
  input  logic [REG_W-1:0]       wdata_i,
  output logic [REG_W-1:0]       rdata_o,
  output logic [NUM_WIN-1:0]     en_o,
  output logic [TYPE_W-1:0]      kind_o  [NUM_WIN],
  output logic [ADDR_W-1:0]      base_o  [NUM_WIN],
  output logic [REG_W-1:0]       limit_o [NUM_WIN],
  output logic [ADDR_W-1:0]      tgt_o   [NUM_WIN]
);

  localparam int HI_W = ADDR_W - REG_W;
  localparam int CH_W = ADDR_W - LOW_W;
  localparam int LC_W = REG_W - LOW_W;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic              en_q;
    logic [TYPE_W-1:0] kind_q;
    logic [CH_W-1:0]   base_q;
    logic [LC_W-1:0]   lim_q;
    logic [CH_W-1:0]   tgt_q;
    logic              hit_w;

    assign hit_w = we_i && (idx_i == IDX_W'(w));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q   <= 1'b0;
        kind_q <= '0;
        base_q <= '0;
        lim_q  <= '0;
        tgt_q  <= '0;
      end else if (hit_w) begin
        case (sel_i)
          FLD_CTRL: begin
            en_q   <= wdata_i[0];
            kind_q <= wdata_i[TYPE_W:1];
          end
          FLD_BASE_LO: base_q[LC_W-1:0]    <= wdata_i[REG_W-1:LOW_W];
          FLD_BASE_HI: base_q[CH_W-1:LC_W] <= wdata_i[HI_W-1:0];
          FLD_LIMIT:   lim_q               <= wdata_i[REG_W-1:LOW_W];
          FLD_TGT_LO:  tgt_q[LC_W-1:0]     <= wdata_i[REG_W-1:LOW_W];
          FLD_TGT_HI:  tgt_q[CH_W-1:LC_W]  <= wdata_i[HI_W-1:0];
          default: ;
        endcase
      end
    end

    assign en_o[w]    = en_q;
    assign kind_o[w]  = kind_q;
    assign base_o[w]  = {base_q, {LOW_W{1'b0}}};
    assign limit_o[w] = {lim_q, {LOW_W{1'b1}}};
    assign tgt_o[w]   = {tgt_q, {LOW_W{1'b0}}};

    AST_EN_ONLY_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(en_q) |-> $past(we_i && idx_i == IDX_W'(w) && sel_i == FLD_CTRL && wdata_i[0])); // R1
  end

  always_comb begin
    rdata_o = '0;
    if (int'(idx_i) < NUM_WIN) begin
      case (sel_i)
        FLD_CTRL:    rdata_o = REG_W'({kind_o[idx_i], en_o[idx_i]});
        FLD_BASE_LO: rdata_o = base_o[idx_i][REG_W-1:0];
        FLD_BASE_HI: rdata_o = REG_W'(base_o[idx_i][ADDR_W-1:REG_W]);
        FLD_LIMIT:   rdata_o = limit_o[idx_i];
        FLD_TGT_LO:  rdata_o = tgt_o[idx_i][REG_W-1:0];
        FLD_TGT_HI:  rdata_o = REG_W'(tgt_o[idx_i][ADDR_W-1:REG_W]);
        default:     rdata_o = '0;
      endcase
    end
  end

  AST_LIMIT_LOW_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == FLD_LIMIT && int'(idx_i) < NUM_WIN) |-> (rdata_o[LOW_W-1:0] == {LOW_W{1'b1}})); // R3

endmodule

// File: rtl/xwt_match.sv
module xwt_match
  import xwt_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int ADDR_W  = 64,
  parameter int REG_W   = 32
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_WIN-1:0] en_i,
  input  logic [TYPE_W-1:0]  kind_i  [NUM_WIN],
  input  logic [ADDR_W-1:0]  base_i  [NUM_WIN],
  input  logic [REG_W-1:0]   limit_i [NUM_WIN],
  output logic [NUM_WIN-1:0] hit_o
);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    logic upper_eq, above_base, below_lim;
    assign upper_eq   = addr_i[ADDR_W-1:REG_W] == base_i[w][ADDR_W-1:REG_W];
    assign above_base = addr_i[REG_W-1:0] >= base_i[w][REG_W-1:0];
    assign below_lim  = addr_i[REG_W-1:0] <= limit_i[w];
    assign hit_o[w]   = en_i[w] && (kind_i[w] == TYPE_MEM) && upper_eq && above_base && below_lim;
  end

endmodule

// File: rtl/xwt_prio.sv
module xwt_prio #(
  parameter int NUM_WIN = 4,
  parameter int IDX_W   = 2
) (
  input  logic [NUM_WIN-1:0] hit_i,
  output logic [NUM_WIN-1:0] grant_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               any_o
);

  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hit_i[w]) begin
        grant_o    = '0;
        grant_o[w] = 1'b1;
        idx_o      = IDX_W'(w);
      end
    end
    any_o = |hit_i;
  end

  always_comb begin
    AST_GRANT_ONEHOT: assert ($onehot0(grant_o)); // R7
    AST_LOWEST_WINS: assert ((hit_i & (grant_o - NUM_WIN'(1))) == '0); // R7
  end

endmodule

// File: rtl/xlat_window_table.sv
module xlat_window_table
  import xwt_pkg::*;
#(
  parameter int NUM_WIN    = 4,
  parameter int ADDR_W     = 64,
  parameter int REG_W      = 32,
  parameter int MIN_REGION = 4096,
  localparam int IDX_W     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic [2:0]        reg_sel_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  output logic [ADDR_W-1:0] rsp_addr_o,
  output logic              rsp_hit_o,
  output logic [IDX_W-1:0]  rsp_idx_o
);

  localparam int LOW_W = chunk_bits(MIN_REGION);

  logic [NUM_WIN-1:0] en;
  logic [TYPE_W-1:0]  kind  [NUM_WIN];
  logic [ADDR_W-1:0]  base  [NUM_WIN];
  logic [REG_W-1:0]   limit [NUM_WIN];
  logic [ADDR_W-1:0]  tgt   [NUM_WIN];
  logic [NUM_WIN-1:0] hit, grant;
  logic [IDX_W-1:0]   win_idx;
  logic               win_any;
  logic [ADDR_W-1:0]  xlat;

  xwt_regfile #(
    .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .REG_W(REG_W), .LOW_W(LOW_W), .IDX_W(IDX_W)
  ) u_regfile (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .idx_i   (reg_idx_i),
    .sel_i   (reg_sel_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .en_o    (en),
    .kind_o  (kind),
    .base_o  (base),
    .limit_o (limit),
    .tgt_o   (tgt)
  );

  xwt_match #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .REG_W(REG_W)) u_match (
    .addr_i  (req_addr_i),
    .en_i    (en),
    .kind_i  (kind),
    .base_i  (base),
    .limit_i (limit),
    .hit_o   (hit)
  );

  xwt_prio #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_prio (
    .hit_i   (hit),
    .grant_o (grant),
    .idx_o   (win_idx),
    .any_o   (win_any)
  );

  // single rebasing adder behind the winner mux
  assign xlat = tgt[win_idx] + ADDR_W'(req_addr_i[REG_W-1:0] - base[win_idx][REG_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_addr_o  <= '0;
      rsp_hit_o   <= 1'b0;
      rsp_idx_o   <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_addr_o <= win_any ? xlat : req_addr_i;
        rsp_hit_o  <= win_any;
        rsp_idx_o  <= win_any ? win_idx : '0;
      end
    end
  end

  AST_RSP_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R8
  AST_NO_RSP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R8
  AST_MISS_PASSTHRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !win_any) |=> (rsp_addr_o == $past(req_addr_i) && !rsp_hit_o && rsp_idx_o == '0)); // R6
  AST_HIT_GRANTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && win_any) |=> (rsp_hit_o && rsp_idx_o == $past(win_idx))); // R7

endmodule

// File: tb/xlat_window_table_bench.sv
module xlat_window_table_bench;

  localparam logic [2:0] S_CTRL = 3'd0, S_BLO = 3'd1, S_BHI = 3'd2, S_LIM = 3'd3,
                         S_TLO = 3'd4, S_THI = 3'd5, S_NONE6 = 3'd6, S_NONE7 = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  idx = '0;
  logic [2:0]  sel = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        req_v = 1'b0;
  logic [63:0] req_a = '0;
  logic        rsp_v;
  logic [63:0] rsp_a;
  logic        rsp_h;
  logic [1:0]  rsp_i;

  logic [31:0] fb_rdata;
  logic        fb_v, fb_h;
  logic [63:0] fb_a;
  logic [0:0]  fb_i;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  xlat_window_table #(.NUM_WIN(4), .ADDR_W(64), .REG_W(32), .MIN_REGION(8192)) u_xlat_window_table (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_idx_i(idx), .reg_sel_i(sel),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .req_valid_i(req_v), .req_addr_i(req_a),
    .rsp_valid_o(rsp_v), .rsp_addr_o(rsp_a), .rsp_hit_o(rsp_h), .rsp_idx_o(rsp_i)
  );

  // unsupported region size: fallback mask
  xlat_window_table #(.NUM_WIN(2), .ADDR_W(64), .REG_W(32), .MIN_REGION(5000)) u_xlat_window_table_fb (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(1'b0), .reg_idx_i(1'b0), .reg_sel_i(S_LIM),
    .reg_wdata_i(32'h0), .reg_rdata_o(fb_rdata), .req_valid_i(1'b0), .req_addr_i(64'h0),
    .rsp_valid_o(fb_v), .rsp_addr_o(fb_a), .rsp_hit_o(fb_h), .rsp_idx_o(fb_i)
  );

  typedef struct packed {
    logic [63:0] a;
    logic        h;
    logic [1:0]  i;
    logic [63:0] x;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{64'h1_0000_0010, 1'b1, 2'd0, 64'h0_8000_0010},  // R5
    '{64'h1_0000_3FFF, 1'b1, 2'd0, 64'h0_8000_3FFF},  // R4 limit edge
    '{64'h1_0000_2000, 1'b1, 2'd0, 64'h0_8000_2000},  // R7 overlap
    '{64'h1_0000_4000, 1'b1, 2'd1, 64'h2_0000_2000},  // R5
    '{64'h1_0000_7FFF, 1'b1, 2'd1, 64'h2_0000_5FFF},  // R4
    '{64'h1_0000_8000, 1'b0, 2'd0, 64'h1_0000_8000},  // R6
    '{64'h0_FFFF_FFFF, 1'b0, 2'd0, 64'h0_FFFF_FFFF},  // R6
    '{64'h0_4000_0100, 1'b0, 2'd0, 64'h0_4000_0100},  // R11
    '{64'h0_5000_0040, 1'b0, 2'd0, 64'h0_5000_0040},  // R4 disabled
    '{64'h2_0000_0010, 1'b0, 2'd0, 64'h2_0000_0010}   // R4 upper word
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] w, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; idx = w; sel = s; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [1:0] w, input logic [2:0] s, input logic [31:0] exp);
    @(negedge clk);
    idx = w; sel = s;
    #1;
    chk(tag, {32'h0, rdata}, {32'h0, exp});
  endtask

  task automatic look(input string tag, input logic [63:0] a, input logic h,
                      input logic [1:0] i, input logic [63:0] x);
    @(negedge clk);
    req_v = 1'b1; req_a = a;
    @(negedge clk);
    req_v = 1'b0;
    chk({tag, " valid"}, {63'h0, rsp_v}, 64'h1);
    chk({tag, " hit"}, {63'h0, rsp_h}, {63'h0, h});
    chk({tag, " idx"}, {62'h0, rsp_i}, {62'h0, i});
    chk({tag, " addr"}, rsp_a, x);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset rsp_valid", {63'h0, rsp_v}, 64'h0);
    rst_n = 1'b1;
    for (int w = 0; w < 4; w++) rd("R1 ctrl after reset", 2'(w), S_CTRL, 32'h0);
    rd("R3 limit after reset", 2'd0, S_LIM, 32'h0000_1FFF);
    @(negedge clk);
    chk("R3 fallback mask", {32'h0, fb_rdata}, 64'h0000_FFFF);
    look("R1 lookup after reset", 64'h1_0000_0010, 1'b0, 2'd0, 64'h1_0000_0010);

    wr(2'd0, S_BLO, 32'h0);        wr(2'd0, S_BHI, 32'h1);
    wr(2'd0, S_LIM, 32'h2000);     wr(2'd0, S_TLO, 32'h8000_0000);
    wr(2'd0, S_THI, 32'h0);        wr(2'd0, S_CTRL, 32'h1);
    wr(2'd1, S_BLO, 32'h2ABC);     wr(2'd1, S_BHI, 32'h1);
    wr(2'd1, S_LIM, 32'h7FFF);     wr(2'd1, S_TLO, 32'h0);
    wr(2'd1, S_THI, 32'h2);        wr(2'd1, S_CTRL, 32'h1);
    wr(2'd2, S_BLO, 32'h4000_0000); wr(2'd2, S_BHI, 32'h0);
    wr(2'd2, S_LIM, 32'h4000_1FFF); wr(2'd2, S_TLO, 32'h0);
    wr(2'd2, S_THI, 32'hA);        wr(2'd2, S_CTRL, 32'h5);
    wr(2'd3, S_BLO, 32'h5000_0000); wr(2'd3, S_BHI, 32'h0);
    wr(2'd3, S_LIM, 32'h5000_0000); wr(2'd3, S_TLO, 32'h0001_0000);
    wr(2'd3, S_THI, 32'h0);        wr(2'd3, S_CTRL, 32'h0);
    wr(2'd0, S_NONE7, 32'hFFFF_FFFF);

    rd("R10 base low chunk bits", 2'd1, S_BLO, 32'h0000_2000);
    rd("R3 limit low ones", 2'd0, S_LIM, 32'h0000_3FFF);
    rd("R2 target high", 2'd1, S_THI, 32'h2);
    rd("R2 limit full write", 2'd3, S_LIM, 32'h5000_1FFF);
    rd("R11 ctrl type and enable", 2'd2, S_CTRL, 32'h5);
    rd("R2 unused select reads zero", 2'd0, S_NONE6, 32'h0);
    rd("R2 unused write no effect", 2'd0, S_BLO, 32'h0);
    rd("R2 unused write no effect ctrl", 2'd0, S_CTRL, 32'h1);

    for (int v = 0; v < NV; v++)
      look($sformatf("R4 R5 R6 R7 vector %0d", v), VEC[v].a, VEC[v].h, VEC[v].i, VEC[v].x);

    // R9: enable window 3 and look up in the same cycle, then the next
    @(negedge clk);
    we = 1'b1; idx = 2'd3; sel = S_CTRL; wdata = 32'h1;
    req_v = 1'b1; req_a = 64'h0_5000_0040;
    @(negedge clk);
    we = 1'b0;
    chk("R9 same cycle lookup old", {63'h0, rsp_h}, 64'h0);
    @(negedge clk);
    req_v = 1'b0;
    chk("R9 next cycle hit", {63'h0, rsp_h}, 64'h1);
    chk("R9 next cycle idx", {62'h0, rsp_i}, 64'h3);
    chk("R9 next cycle addr", rsp_a, 64'h0_0001_0040);
    @(negedge clk);
    chk("R8 idle rsp_valid", {63'h0, rsp_v}, 64'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule